// File: doc/BRIEF.md
# Generalized Streaming Width Converter

This block re-packs a valid/ready stream of `IN_W`-bit words into a valid/ready stream of `OUT_W`-bit words. The two widths may be any values, and neither has to divide the other. The conversion happens in a single stage through one residue register that is `IN_W + OUT_W` bits wide. Bits are packed LSB-first: the first bit received becomes bit 0 of the first output word. When a wide input word is split, its leftover high bits stay at the bottom of the residue and lead the next output word.

Work is organised in frames. Each frame is exactly `IN_WORDS` input words and `OUT_WORDS` output words. If the output side of a frame carries more bits than the input side, the tail is filled with zeros. If it carries fewer, the surplus input words are still accepted and then dropped. The residue is cleared between frames. After `REPS` frames the block stops and waits for a reset. When `IN_W == OUT_W`, a generate branch replaces the residue with a direct combinational path, and only the frame and repetition counting is kept. In that variant `IN_WORDS` must equal `OUT_WORDS`.

The controller has three states:
- **LOAD**: input words of the current frame are still owed.
- **DRAIN**: all input words are in, and the remaining output words are emitted from the residue and zero fill.
- **HALT**: the last repetition has finished.

The transitions are:
- **load_to_drain**: the last input word is accepted while output words are still owed.
- **frame_restart**: both counts complete with repetitions remaining. It is taken from LOAD or DRAIN and leads back to LOAD.
- **frame_to_halt**: both counts complete on the final repetition.
- **halt_hold**: HALT stays in HALT until reset.

Top module: `swc_convert`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0, `in_ready` is 1 and the residue is empty.
- R2: Packing is LSB-first. Within a frame, output word k equals bits [k*OUT_W +: OUT_W] of the concatenation of that frame's input words, with input word 0 in the least significant position.
- R3: The residue holds at most IN_W+OUT_W bits. While output words are still owed, an input word is accepted only if the held bit count plus IN_W fits, so with `out_ready` low and an empty residue, 12-bit inputs into an 8-bit output are accepted exactly once.
- R4: An output word is offered only when at least OUT_W bits are held, or when the frame's input words are all in. For 8-bit into 20-bit, `out_valid` stays 0 after 8 and 16 bits and rises after 24.
- R5: Output bits of a frame beyond the frame's input bits are zero.
- R6: Exactly IN_WORDS input words are accepted per frame. Words arriving after all OUT_WORDS outputs are done are accepted and discarded.
- R7: The residue is cleared at each frame boundary, so output word 0 of every frame depends only on that frame's inputs.
- R8: After REPS frames, `in_ready` and `out_valid` stay 0 until reset.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays stable. No word is lost or duplicated under backpressure on either side.
- R10: With IN_W equal to OUT_W, `out_data` equals `in_data`, `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle while the block is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word accepted this cycle when valid |
| in_data | input | IN_W | Input word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | OUT_W | Output word |

## Verification
A wrong bit count in the residue shows at the ports as a shifted or torn output word. It also shows as a wrong number of inputs accepted under a stalled output: the first input is refused too early or a second one is let in. This appears within one or two transfers. A frame counter that is off shows as a missing zero fill, a lost crop, or a halt that comes a frame early or late. Because the bench compares every output word of every frame, such an error surfaces at the first frame boundary. A residue that is not cleared corrupts word 0 of the following frame.

// File: rtl/swc_pkg.sv
package swc_pkg;

    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_HALT  = 2'd2
    } swc_state_e;

endpackage

// File: rtl/swc_frame_ctrl.sv
module swc_frame_ctrl
    import swc_pkg::*;
#(
    parameter int IN_WORDS  = 5,
    parameter int OUT_WORDS = 8,
    parameter int REPS      = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_fire,
    input  logic       out_fire,
    output swc_state_e state,
    output logic       in_left,
    output logic       out_left,
    output logic       frame_end
);

    localparam int IC_W = $clog2(IN_WORDS + 1);
    localparam int OC_W = $clog2(OUT_WORDS + 1);
    localparam int RC_W = $clog2(REPS + 1);

    swc_state_e      state_n;
    logic [IC_W-1:0] in_cnt, in_cnt_n;
    logic [OC_W-1:0] out_cnt, out_cnt_n;
    logic [RC_W-1:0] rep_cnt;
    logic            last_rep;
    logic            in_done_n;

    always_comb begin
        in_cnt_n  = in_cnt + IC_W'(in_fire);
        out_cnt_n = out_cnt + OC_W'(out_fire);
        in_done_n = (in_cnt_n == IC_W'(IN_WORDS));
        frame_end = in_done_n && (out_cnt_n == OC_W'(OUT_WORDS));
        last_rep  = (rep_cnt == RC_W'(REPS - 1));
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_LOAD: begin
                if (frame_end)      state_n = last_rep ? ST_HALT : ST_LOAD;
                else if (in_done_n) state_n = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (frame_end)      state_n = last_rep ? ST_HALT : ST_LOAD;
            end
            ST_HALT:                state_n = ST_HALT;
            default:                state_n = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_LOAD;
        else     state <= state_n;
    end

    // frame and repetition counters
    always_ff @(posedge clk) begin
        if (rst) begin
            in_cnt  <= '0;
            out_cnt <= '0;
            rep_cnt <= '0;
        end else if (frame_end) begin
            in_cnt  <= '0;
            out_cnt <= '0;
            rep_cnt <= rep_cnt + RC_W'(1);
        end else begin
            in_cnt  <= in_cnt_n;
            out_cnt <= out_cnt_n;
        end
    end

    // outputs
    always_comb begin
        in_left  = (state == ST_LOAD);
        out_left = (state != ST_HALT) && (out_cnt != OC_W'(OUT_WORDS));
    end

    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        state == ST_HALT |=> state == ST_HALT);

    assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        state == ST_HALT |-> !in_fire && !out_fire);

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        in_cnt <= IC_W'(IN_WORDS) && out_cnt <= OC_W'(OUT_WORDS));

    assert_drain_no_input_R6: assert property (@(posedge clk) disable iff (rst)
        state == ST_DRAIN |-> !in_fire);

endmodule

// File: rtl/swc_residue_buf.sv
module swc_residue_buf #(
    parameter int IN_W  = 12,
    parameter int OUT_W = 8
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   clear,
    input  logic                                   in_take,
    input  logic [IN_W-1:0]                        in_data,
    input  logic                                   out_take,
    output logic [$clog2(IN_W + OUT_W + 1)-1:0]    fill,
    output logic [OUT_W-1:0]                       head,
    output logic                                   room
);

    localparam int BUF_W  = IN_W + OUT_W;
    localparam int FILL_W = $clog2(BUF_W + 1);

    logic [BUF_W-1:0]  store, store_s, store_n;
    logic [FILL_W-1:0] fill_s, fill_n;

    always_comb begin
        room = ({1'b0, fill} + (FILL_W + 1)'(IN_W)) <= (FILL_W + 1)'(BUF_W);
        head = store[OUT_W-1:0];

        // drop the emitted word first
        if (out_take) begin
            store_s = store >> OUT_W;
            fill_s  = (fill >= FILL_W'(OUT_W)) ? fill - FILL_W'(OUT_W) : '0;
        end else begin
            store_s = store;
            fill_s  = fill;
        end

        // then append the new word above the residue
        if (in_take) begin
            store_n = store_s | (BUF_W'(in_data) << fill_s);
            fill_n  = fill_s + FILL_W'(IN_W);
        end else begin
            store_n = store_s;
            fill_n  = fill_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            store <= '0;
            fill  <= '0;
        end else begin
            store <= store_n;
            fill  <= fill_n;
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        fill <= FILL_W'(BUF_W));

    assert_take_room_R3: assert property (@(posedge clk) disable iff (rst)
        in_take |-> room);

    assert_frame_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clear |=> fill == '0);

endmodule

// File: rtl/swc_convert.sv
module swc_convert
    import swc_pkg::*;
#(
    parameter int IN_W      = 12,
    parameter int OUT_W     = 8,
    parameter int IN_WORDS  = 5,
    parameter int OUT_WORDS = 8,
    parameter int REPS      = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data
);

    swc_state_e state;
    logic       in_left, out_left, frame_end;
    logic       in_fire, out_fire;

    swc_frame_ctrl #(
        .IN_WORDS  (IN_WORDS),
        .OUT_WORDS (OUT_WORDS),
        .REPS      (REPS)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_fire   (in_fire),
        .out_fire  (out_fire),
        .state     (state),
        .in_left   (in_left),
        .out_left  (out_left),
        .frame_end (frame_end)
    );

    generate
        if (IN_W == OUT_W) begin : g_pass
            assign in_ready  = out_ready && in_left;
            assign out_valid = in_valid && in_left;
            assign out_data  = in_data;
            assign in_fire   = in_valid && out_ready && in_left;
            assign out_fire  = in_fire;
        end else begin : g_conv
            localparam int FILL_W = $clog2(IN_W + OUT_W + 1);

            logic [FILL_W-1:0] fill;
            logic [OUT_W-1:0]  head;
            logic              room;
            logic              in_take;

            swc_residue_buf #(
                .IN_W  (IN_W),
                .OUT_W (OUT_W)
            ) u_buf (
                .clk      (clk),
                .rst      (rst),
                .clear    (frame_end),
                .in_take  (in_take),
                .in_data  (in_data),
                .out_take (out_fire),
                .fill     (fill),
                .head     (head),
                .room     (room)
            );

            assign in_ready  = in_left && (!out_left || room);
            assign out_valid = out_left && ((fill >= FILL_W'(OUT_W)) || (state == ST_DRAIN));
            assign out_data  = head;
            assign in_fire   = in_valid && in_ready;
            assign out_fire  = out_valid && out_ready;
            assign in_take   = in_fire && out_left;

            assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
                out_valid && !out_ready |=> out_valid && $stable(out_data));

            assert_short_word_R4: assert property (@(posedge clk) disable iff (rst)
                out_fire && (fill < FILL_W'(OUT_W)) |-> state == ST_DRAIN);
        end
    endgenerate

endmodule

// File: tb/swc_convert_tb.sv
`timescale 1ns/100ps
module swc_convert_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int n_checks = 0;
    int n_err    = 0;

    // main: 12 -> 8, 5 in / 8 out words, 3 reps (zero fill)
    logic        m_in_valid = 0, m_in_ready, m_out_valid, m_out_ready = 0;
    logic [11:0] m_in_data = '0;
    logic [7:0]  m_out_data;
    // crop: 8 -> 20, 7 in / 2 out words, 2 reps
    logic        c_in_valid = 0, c_in_ready, c_out_valid, c_out_ready = 0;
    logic [7:0]  c_in_data = '0;
    logic [19:0] c_out_data;
    // equal widths: 16 -> 16, 4 words, 2 reps
    logic        p_in_valid = 0, p_in_ready, p_out_valid, p_out_ready = 0;
    logic [15:0] p_in_data = '0;
    logic [15:0] p_out_data;

    swc_convert #(.IN_W(12), .OUT_W(8), .IN_WORDS(5), .OUT_WORDS(8), .REPS(3)) u_dut (
        .clk(clk), .rst(rst), .in_valid(m_in_valid), .in_ready(m_in_ready), .in_data(m_in_data),
        .out_valid(m_out_valid), .out_ready(m_out_ready), .out_data(m_out_data));

    swc_convert #(.IN_W(8), .OUT_W(20), .IN_WORDS(7), .OUT_WORDS(2), .REPS(2)) u_crop (
        .clk(clk), .rst(rst), .in_valid(c_in_valid), .in_ready(c_in_ready), .in_data(c_in_data),
        .out_valid(c_out_valid), .out_ready(c_out_ready), .out_data(c_out_data));

    swc_convert #(.IN_W(16), .OUT_W(16), .IN_WORDS(4), .OUT_WORDS(4), .REPS(2)) u_pass (
        .clk(clk), .rst(rst), .in_valid(p_in_valid), .in_ready(p_in_ready), .in_data(p_in_data),
        .out_valid(p_out_valid), .out_ready(p_out_ready), .out_data(p_out_data));

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] main_word(int f, int i);
        return 12'(f * 1000 + i * 733 + 291);
    endfunction

    function automatic logic [7:0] exp_main(int f, int k);
        logic [63:0] s = '0;
        for (int i = 0; i < 5; i++) s[i*12 +: 12] = main_word(f, i);
        return s[k*8 +: 8];
    endfunction

    function automatic logic [7:0] crop_word(int f, int i);
        return 8'(f * 61 + i * 29 + 7);
    endfunction

    function automatic logic [19:0] exp_crop(int f, int k);
        logic [63:0] s = '0;
        for (int i = 0; i < 7; i++) s[i*8 +: 8] = crop_word(f, i);
        return s[k*20 +: 20];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        m_in_valid = 0; m_out_ready = 0;
        c_in_valid = 0; c_out_ready = 0;
        p_in_valid = 0; p_out_ready = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic test_reset();
        do_reset();
        @(negedge clk); #1;
        check(m_out_valid == 1'b0, "R1 out_valid", 64'(m_out_valid), 64'd0);
        check(m_in_ready == 1'b1, "R1 in_ready", 64'(m_in_ready), 64'd1);
        check(c_out_valid == 1'b0, "R1 crop out_valid", 64'(c_out_valid), 64'd0);
    endtask

    // stalled output: room limit and held word
    task automatic test_room_limit();
        int acc = 0;
        do_reset();
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            m_in_valid = 1'b1;
            m_in_data  = main_word(0, acc);
            #1;
            if (m_in_valid && m_in_ready) acc++;
        end
        m_in_valid = 1'b0;
        check(acc == 1, "R3 accepted under stall", 64'(acc), 64'd1);
        check(m_in_ready == 1'b0, "R3 in_ready full", 64'(m_in_ready), 64'd0);
        check(m_out_valid == 1'b1, "R9 out_valid held", 64'(m_out_valid), 64'd1);
        check(m_out_data == exp_main(0, 0), "R9 held data", 64'(m_out_data), 64'(exp_main(0, 0)));
    endtask

    // fill threshold before a wide output word appears
    task automatic test_threshold();
        logic [63:0] exp_bits [3] = '{64'd0, 64'd0, 64'd1};
        do_reset();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            c_in_valid = 1'b1;
            c_in_data  = crop_word(0, i);
            #1;
            check(c_in_ready == 1'b1, "R3 crop accept", 64'(c_in_ready), 64'd1);
            @(negedge clk);
            c_in_valid = 1'b0;
            #1;
            check(c_out_valid == exp_bits[i][0], "R4 valid after bits", 64'(c_out_valid), exp_bits[i]);
        end
        check(c_in_ready == 1'b0, "R3 crop full", 64'(c_in_ready), 64'd0);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk); #1;
            check(c_out_valid && c_out_data == (exp_crop(0, 0) & 20'hFFFFF),
                  "R9 crop held word", 64'(c_out_data), 64'(exp_crop(0, 0)));
        end
    endtask

    task automatic run_main(input int stall);
        int nin = 0, nout = 0, cyc = 0;
        logic        held_v = 0;
        logic [7:0]  held_d = '0;
        do_reset();
        while ((nout < 24 || nin < 15) && cyc < 3000) begin
            @(negedge clk);
            m_in_valid  = (nin < 15) && (stall == 0 || (cyc % 3) != 1);
            m_in_data   = main_word(nin / 5, nin % 5);
            m_out_ready = (stall == 0) || ((cyc % 4) < 2);
            #1;
            if (held_v)
                check(m_out_valid && m_out_data == held_d, "R9 stall stable", 64'(m_out_data), 64'(held_d));
            held_v = m_out_valid && !m_out_ready;
            held_d = m_out_data;
            if (m_in_valid && m_in_ready) nin++;
            if (m_out_valid && m_out_ready) begin
                check(m_out_data == exp_main(nout / 8, nout % 8),
                      (nout % 8 == 7) ? "R5 zero fill word" : (nout % 8 == 0 && nout > 0) ? "R7 fresh frame" : "R2 packed word",
                      64'(m_out_data), 64'(exp_main(nout / 8, nout % 8)));
                nout++;
            end
            cyc++;
        end
        check(nin == 15, "R6 main inputs", 64'(nin), 64'd15);
        check(nout == 24, "R8 main outputs", 64'(nout), 64'd24);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            m_in_valid = 1'b1; m_out_ready = 1'b1;
            #1;
            check(!m_in_ready && !m_out_valid, "R8 halted", 64'({m_in_ready, m_out_valid}), 64'd0);
        end
        m_in_valid = 1'b0;
    endtask

    task automatic run_crop();
        int nin = 0, nout = 0, cyc = 0;
        do_reset();
        while ((nout < 4 || nin < 14) && cyc < 3000) begin
            @(negedge clk);
            c_in_valid  = (nin < 14) && ((cyc % 5) != 2);
            c_in_data   = crop_word(nin / 7, nin % 7);
            c_out_ready = (cyc % 3) != 0;
            #1;
            if (c_in_valid && c_in_ready) nin++;
            if (c_out_valid && c_out_ready) begin
                check(c_out_data == exp_crop(nout / 2, nout % 2),
                      (nout == 2) ? "R7 crop fresh frame" : "R2 crop word",
                      64'(c_out_data), 64'(exp_crop(nout / 2, nout % 2)));
                nout++;
            end
            cyc++;
        end
        check(nin == 14, "R6 surplus accepted", 64'(nin), 64'd14);
        check(nout == 4, "R6 crop outputs", 64'(nout), 64'd4);
        @(negedge clk);
        c_in_valid = 1'b1; c_out_ready = 1'b1;
        #1;
        check(!c_in_ready && !c_out_valid, "R8 crop halted", 64'({c_in_ready, c_out_valid}), 64'd0);
        c_in_valid = 1'b0;
    endtask

    task automatic run_pass();
        int n = 0, cyc = 0;
        do_reset();
        while (n < 8 && cyc < 500) begin
            @(negedge clk);
            p_in_valid  = (cyc % 3) != 2;
            p_in_data   = 16'(n * 4099 + 17);
            p_out_ready = (cyc % 4) != 1;
            #1;
            check(p_in_ready == p_out_ready && p_out_valid == p_in_valid && p_out_data == p_in_data,
                  "R10 pass-through", 64'({p_in_ready, p_out_valid, p_out_data}),
                  64'({p_out_ready, p_in_valid, p_in_data}));
            if (p_in_valid && p_in_ready) n++;
            cyc++;
        end
        @(negedge clk);
        p_in_valid = 1'b1; p_out_ready = 1'b1;
        #1;
        check(!p_in_ready && !p_out_valid, "R8 pass halted", 64'({p_in_ready, p_out_valid}), 64'd0);
        p_in_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        test_reset();
        test_room_limit();
        test_threshold();
        run_main(0);
        run_main(1);
        run_crop();
        run_pass();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule